// File: doc/BRIEF.md
# Five-Channel Buffered PWM Timer

The block generates five pulse-width-modulated outputs from down-counting timers. Software programs a period word and a compare word into a pair of buffer registers for each channel. The working counter and the working compare take copies of those buffers only at defined moments: while a channel's manual-load bit is held, or when the counter runs out and the channel is set to reload. This lets software change a waveform without tearing the period that is in progress.

The counters advance only when their own tick-enable input is high, so an external prescaler or divider sets the time base of each channel. One control word holds the run, manual-load, polarity and reload bits of every channel. The bit layout is irregular, because software that decodes it depends on that layout. Two general configuration words are also stored; they are meant for the tick source outside the block.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads 0 and every `pwm_o` bit is 0.
- R2: Reads and writes use these offsets: configuration words at 0x00 and 0x04 (full 32 bits); the period buffer of channel n at 0x0C+0xC·n; the compare buffer of channel n at 0x10+0xC·n. A buffer keeps the low CNT_W bits of a write and reads back zero-extended. Reads return the buffer, never the working counter. Unmapped offsets read 0, and writes to them change nothing.
- R3: The control word is at 0x08. Channel 0 uses bits 3:0, and channel n≥1 uses the 4-bit group n+1. Within a group: bit 0 run, bit 1 manual load, bit 2 invert, bit 3 reload. Unused bits read 0, so writing all ones reads back 0x007FFF0F.
- R4: The last channel has no invert bit. Its reload bit is bit 2 of its group (bit 22).
- R5: While manual load is set, the working counter and compare copy the buffers, the raw level is 0, and no counting happens.
- R6: A running channel decrements once per cycle in which its tick input is high. A period word of N gives N+1 ticks per period. A channel holds its count when it is not running or gets no tick.
- R7: The raw level is 0 in the first count of a period (value N). It is 1 in every later count whose value is at or below the compare. With invert set and compare N−d, the output is high for d ticks of each period.
- R8: A compare of all ones never matches, so the raw level stays 0 all period. With invert set, this gives 100% duty.
- R9: With reload set, a tick at count 0 reloads counter and compare from the buffers. Buffer writes take effect only at the next period.
- R10: With reload clear, a tick at count 0 stops the channel. The output then sits at its idle level until the next manual load.
- R11: `pwm_o` is the raw level XOR the invert bit. A channel that is not running drives its invert bit.
- R12: Each channel depends only on its own tick and control bits; ticking one channel leaves the others' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Byte offset for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| tick_i | input | 5 | Per-channel count enable |
| pwm_o | output | 5 | PWM outputs |

## Verification
The bench runs a channel with a mid-range compare over several periods, which separates the reload count from the compare window and shows whether the duty length is exact. A compare of all ones, and a compare of 0, show whether the never-match case and the last-count-only case are handled. A buffer change in the middle of a period shows whether reload waits for the period end. A one-shot run, a held manual load, and a run on the last channel test the stop behaviour, the suppression during a held load, and the displaced reload bit. Every tick on one channel is also checked against the unchanged outputs of the other four.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef struct packed {
    logic start;
    logic upd;
    logic inv;
    logic arl;
  } chan_ctl_t;

  localparam int OFS_CFG0   = 'h00;
  localparam int OFS_CFG1   = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_BUF0   = 'h0C;
  localparam int BUF_STRIDE = 'h0C;

  // control groups skip one slot after channel 0
  function automatic int ctl_group(input int ch);
    return (ch == 0) ? 0 : ch + 1;
  endfunction

endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic [DW-1:0]                 rdata_o,
  output chan_ctl_t [NUM_CH-1:0]        ctl_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cnt_buf_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_buf_o
);

  function automatic logic [DW-1:0] ctrl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (ch == NUM_CH - 1) m[4*ctl_group(ch) +: 3] = 3'b111;
      else                  m[4*ctl_group(ch) +: 4] = 4'hF;
    end
    return m;
  endfunction

  function automatic logic [AW-1:0] cnt_ofs(input int ch);
    return AW'(OFS_BUF0 + BUF_STRIDE * ch);
  endfunction

  function automatic logic [AW-1:0] cmp_ofs(input int ch);
    return AW'(OFS_BUF0 + BUF_STRIDE * ch + 4);
  endfunction

  localparam logic [DW-1:0] CTRL_MASK = ctrl_mask();

  logic [DW-1:0]                cfg0_q, cfg1_q, ctrl_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf_q, cmp_buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_q    <= '0;
      cfg1_q    <= '0;
      ctrl_q    <= '0;
      cnt_buf_q <= '0;
      cmp_buf_q <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(OFS_CFG0)) cfg0_q <= wdata_i;
      if (addr_i == AW'(OFS_CFG1)) cfg1_q <= wdata_i;
      if (addr_i == AW'(OFS_CTRL)) ctrl_q <= wdata_i & CTRL_MASK;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (addr_i == cnt_ofs(ch)) cnt_buf_q[ch] <= wdata_i[CNT_W-1:0];
        if (addr_i == cmp_ofs(ch)) cmp_buf_q[ch] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFS_CFG0)) rdata_o = cfg0_q;
    if (addr_i == AW'(OFS_CFG1)) rdata_o = cfg1_q;
    if (addr_i == AW'(OFS_CTRL)) rdata_o = ctrl_q;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr_i == cnt_ofs(ch)) rdata_o = DW'(cnt_buf_q[ch]);
      if (addr_i == cmp_ofs(ch)) rdata_o = DW'(cmp_buf_q[ch]);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ctl
    localparam int G = ctl_group(i);
    if (i == NUM_CH - 1) begin : g_last
      // last channel: no invert, reload sits at position 2
      assign ctl_o[i] = {ctrl_q[4*G], ctrl_q[4*G+1], 1'b0, ctrl_q[4*G+2]};
    end else begin : g_std
      assign ctl_o[i] = {ctrl_q[4*G], ctrl_q[4*G+1], ctrl_q[4*G+2], ctrl_q[4*G+3]};
    end
  end

  assign cnt_buf_o = cnt_buf_q;
  assign cmp_buf_o = cmp_buf_q;

  a_r2_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(OFS_CFG0)) |=> (cfg0_q == $past(wdata_i)));

  a_r3_ctrl_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(OFS_CTRL)) |-> ((rdata_o & ~CTRL_MASK) == '0));

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  chan_ctl_t        ctl_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic             pwm_o
);

  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic [CNT_W-1:0] cnt_q, cmp_q, cnt_dec;
  logic             raw_q, halt_q, step, hit_next;

  assign step     = ctl_i.start && !ctl_i.upd && !halt_q && tick_i;
  assign cnt_dec  = cnt_q - CNT_W'(1);
  assign hit_next = (cmp_q != ALL1) && (cnt_dec <= cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      raw_q  <= 1'b0;
      halt_q <= 1'b0;
    end else if (ctl_i.upd) begin
      cnt_q  <= cnt_buf_i;
      cmp_q  <= cmp_buf_i;
      raw_q  <= 1'b0;
      halt_q <= 1'b0;
    end else if (step) begin
      if (cnt_q == '0) begin
        raw_q <= 1'b0;
        if (ctl_i.arl) begin
          cnt_q <= cnt_buf_i;
          cmp_q <= cmp_buf_i;
        end else begin
          halt_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_dec;
        raw_q <= hit_next;
      end
    end
  end

  assign pwm_o = (ctl_i.start & raw_q) ^ ctl_i.inv;

  a_r5_upd_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.upd |=> (cnt_q == $past(cnt_buf_i)) && (cmp_q == $past(cmp_buf_i)) && !raw_q);

  a_r6_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.start && !ctl_i.upd && !halt_q && tick_i && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.upd && (!ctl_i.start || !tick_i)) |=> $stable(cnt_q));

  a_r8_allones_nomatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q == ALL1) |-> !raw_q);

  a_r9_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt_q == '0 && ctl_i.arl) |=> (cnt_q == $past(cnt_buf_i)) && !raw_q);

  a_r10_stay_halted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !ctl_i.upd) |=> halt_q && $stable(cnt_q) && !raw_q);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [NUM_CH-1:0] tick_i,
  output logic [NUM_CH-1:0] pwm_o
);

  chan_ctl_t [NUM_CH-1:0]       ctl;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf, cmp_buf;

  pwm_timer_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .AW(AW), .DW(DW)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .ctl_o     (ctl),
    .cnt_buf_o (cnt_buf),
    .cmp_buf_o (cmp_buf)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i[i]),
      .ctl_i     (ctl[i]),
      .cnt_buf_i (cnt_buf[i]),
      .cmp_buf_i (cmp_buf[i]),
      .pwm_o     (pwm_o[i])
    );

    // R12: an untouched, idle channel keeps its output
    a_r12_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i[i] && !reg_we_i && !ctl[i].upd) |=> $stable(pwm_o[i]));
  end

endmodule

// File: tb/tb_pwm_timer.sv
`timescale 1ns/1ps
module tb_pwm_timer;

  localparam int NCH = 5;
  localparam logic [15:0] ALL1 = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] tick = '0;
  logic [NCH-1:0] pwm;

  pwm_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_i(tick), .pwm_o(pwm)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int    due;
    int    ch;
    logic  exp;
    string tag;
  } sb_item_t;

  sb_item_t    sb[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [31:0] sh = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare due scoreboard items
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      sb_item_t it;
      it = sb.pop_front();
      chk(it.tag, 32'(pwm[it.ch]), 32'(it.exp));
    end
  end

  function automatic logic [7:0] cnt_ofs(input int ch);
    return 8'(12 + 12 * ch);
  endfunction

  function automatic logic [7:0] cmp_ofs(input int ch);
    return 8'(16 + 12 * ch);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  // R3/R4 layout: group 0 for ch0, ch+1 otherwise; last channel reload at pos 2
  task automatic set_ctl(input int ch, input bit s, input bit u, input bit inv, input bit a);
    int g;
    g = (ch == 0) ? 0 : ch + 1;
    sh[4*g +: 4] = 4'h0;
    sh[4*g]   = s;
    sh[4*g+1] = u;
    if (ch == NCH - 1) sh[4*g+2] = a;
    else begin sh[4*g+2] = inv; sh[4*g+3] = a; end
    wr(8'h08, sh);
  endtask

  // driver: pulse one tick, push expected level of ticked and other channels (R12)
  task automatic tick_exp(input int ch, input logic exp, input string tag);
    logic [NCH-1:0] snap;
    @(negedge clk);
    snap = pwm;
    tick = NCH'(1) << ch;
    for (int o = 0; o < NCH; o++) begin
      sb_item_t it;
      it.due = cyc + 1;
      it.ch  = o;
      it.exp = (o == ch) ? exp : snap[o];
      it.tag = (o == ch) ? tag : "R12 untouched channel";
      sb.push_back(it);
    end
    @(negedge clk);
    tick = '0;
  endtask

  // R6/R7 expected level from period word n, compare c, polarity inv
  task automatic tick_run(input int ch, input int cnt, input int n, input logic [15:0] c,
                          input bit inv, input int ph0, input string tag);
    for (int i = 1; i <= cnt; i++) begin
      int ph, v;
      logic e;
      ph = (ph0 + i) % (n + 1);
      v  = n - ph;
      e  = inv ^ ((ph != 0) && (c != ALL1) && (v <= int'(c)));
      tick_exp(ch, e, tag);
    end
  endtask

  task automatic setup(input int ch, input int n, input logic [15:0] c, input bit inv, input bit a);
    wr(cnt_ofs(ch), 32'(n));
    wr(cmp_ofs(ch), 32'(c));
    set_ctl(ch, 1'b0, 1'b1, inv, a);
    set_ctl(ch, 1'b1, 1'b0, inv, a);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 pwm after reset", 32'(pwm), 32'h0);
    rd_chk(8'h08, 32'h0, "R1 control after reset");
    rd_chk(8'h0C, 32'h0, "R1 period buffer after reset");
    rd_chk(8'h00, 32'h0, "R1 config after reset");

    // R2 register map
    wr(8'h00, 32'hA5A5_1234);
    wr(8'h04, 32'h0F0F_8001);
    rd_chk(8'h00, 32'hA5A5_1234, "R2 config word 0");
    rd_chk(8'h04, 32'h0F0F_8001, "R2 config word 1");
    for (int ch = 0; ch < NCH; ch++) begin
      wr(cnt_ofs(ch), 32'hFFFF_0100 + 32'(ch));
      wr(cmp_ofs(ch), 32'hFFFF_0200 + 32'(ch));
    end
    for (int ch = 0; ch < NCH; ch++) begin
      rd_chk(cnt_ofs(ch), 32'h0000_0100 + 32'(ch), "R2 period buffer readback");
      rd_chk(cmp_ofs(ch), 32'h0000_0200 + 32'(ch), "R2 compare buffer readback");
    end
    wr(8'h44, 32'hFFFF_FFFF);
    rd_chk(8'h44, 32'h0, "R2 unmapped read");
    rd_chk(8'h0C, 32'h0000_0100, "R2 unmapped write ignored");

    // R3/R4 control layout
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk(8'h08, 32'h007F_FF0F, "R3 R4 control implemented bits");
    sh = '0;
    wr(8'h08, sh);
    rd_chk(8'h0C, 32'h0000_0100, "R2 read returns buffer not counter");

    // R11 idle level follows invert
    @(negedge clk);
    chk("R11 idle all zero", 32'(pwm), 32'h0);
    set_ctl(3, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R11 idle with invert", 32'(pwm[3]), 32'h1);
    tick_exp(3, 1'b1, "R11 tick ignored when stopped");
    set_ctl(3, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11 idle without invert", 32'(pwm[3]), 32'h0);

    // R6 R7 R9: ch0 period 4, compare 2, inverted -> high 2 of 5
    setup(0, 4, 16'd2, 1'b1, 1'b1);
    chk("R7 level at reload count", 32'(pwm[0]), 32'h1);
    tick_run(0, 10, 4, 16'd2, 1'b1, 0, "R7 duty waveform");
    wr(cnt_ofs(0), 32'd2);
    wr(cmp_ofs(0), 32'd0);
    tick_run(0, 4, 4, 16'd2, 1'b1, 0, "R9 old period kept");
    tick_run(0, 6, 2, 16'd0, 1'b1, -1, "R9 new buffers after reload");

    // R8 all-ones compare
    setup(1, 3, ALL1, 1'b1, 1'b1);
    tick_run(1, 8, 3, ALL1, 1'b1, 0, "R8 full duty inverted");
    set_ctl(1, 1'b1, 1'b0, 1'b0, 1'b1);
    tick_run(1, 4, 3, ALL1, 1'b0, 0, "R8 never matches normal");

    // R10 one-shot: ch2 period 3, compare 1, no reload
    setup(2, 3, 16'd1, 1'b0, 1'b0);
    for (int i = 1; i <= 8; i++) begin
      logic e;
      e = (i <= 3) ? ((3 - i) <= 1) : 1'b0;
      tick_exp(2, e, "R10 one-shot stop");
    end

    // R4 last channel reload at group position 2
    setup(4, 2, 16'd0, 1'b0, 1'b1);
    tick_run(4, 6, 2, 16'd0, 1'b0, 0, "R4 last channel reloads");

    // R5 held manual load suppresses counting
    wr(cnt_ofs(3), 32'd5);
    wr(cmp_ofs(3), 32'd2);
    set_ctl(3, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) tick_exp(3, 1'b1, "R5 held manual load");
    set_ctl(3, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R5 released at reload level", 32'(pwm[3]), 32'h1);
    tick_run(3, 8, 5, 16'd2, 1'b1, 0, "R5 R6 count from buffer");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule